// File: doc/BRIEF.md
# Intra/Predicted Frame Sequencer

This block sits at the front of a video encoder and chooses, once per frame, whether the frame is coded as an intra (I) frame or a predicted (P) frame. A new frame is recognised on the low-to-high transition of a frame-start level. At that moment the block also captures a quantization parameter, limits it to the legal range, and updates a frame index that the header logic uses. All three results stay constant until the next frame start.

The group-of-pictures length is set by an 8-bit run length: after every I frame, that many P frames follow before the next I frame. A one-cycle force request may arrive at any time. It is remembered and turns the next frame into an I frame, and that I frame restarts the run. Only the I and P types exist. Everything runs on one clock with an asynchronous active-low reset.

Top module: `gop_ctrl`

## Requirements
- R1: A frame begins only on a clock where `frm_start` is 1 and was 0 on the previous clock. Holding `frm_start` high starts no further frames, and `frame_go` stays 0.
- R2: After reset, before the first frame, the outputs are `is_intra`=1, `qp_out`=0 and `frame_idx`=0. The first frame after reset is always an I frame.
- R3: With a run length of N (1 to 255), the frames repeat the pattern one I frame followed by N P frames (`is_intra`=1 for I, 0 for P).
- R4: A run length of 0 makes every frame an I frame.
- R5: At each frame start, `qp_out` takes `qp_in` when `qp_in` is 51 or less, and takes 51 otherwise.
- R6: A one-cycle `force_intra` pulse seen between frame starts, or in the same cycle as a frame start, makes that next frame an I frame. The P run counts again from that I frame. The pulse has no effect on the current frame's outputs.
- R7: `frame_idx` is 0 on every I frame and is one more than its previous value on every P frame.
- R8: `is_intra`, `qp_out` and `frame_idx` change only in the cycle after a frame start. Changes to `p_run` and `qp_in` between frame starts do not affect the current frame.
- R9: `frame_go` is 1 for exactly one cycle, the first cycle in which the new frame's outputs are visible.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| frm_start | input | 1 | Frame-start level; its rising edge opens a frame |
| force_intra | input | 1 | One-cycle request to make the next frame an I frame |
| p_run | input | 8 | Number of P frames after each I frame |
| qp_in | input | 6 | Requested quantization parameter |
| is_intra | output | 1 | 1 = I frame, 0 = P frame |
| qp_out | output | 6 | Captured QP, limited to 51 |
| frame_idx | output | 8 | Index within the group: 0 on I, counts up on P |
| frame_go | output | 1 | One-cycle marker of a new frame's first cycle |

## Verification
The two functions that can meet in one cycle are the force request and the frame-start edge. Their collision is provoked by raising `force_intra` on the same clock as the `frm_start` edge, in the middle of a P run. The result is judged by requiring that very frame to be an I frame with index 0, and the following frame to be a P frame with index 1. A second case raises the force mid-frame and checks that the current P frame's outputs stay unchanged until the next edge.

// File: rtl/gop_pkg.sv
`timescale 1ns/1ps
package gop_pkg;
    typedef enum logic {
        FT_P = 1'b0,
        FT_I = 1'b1
    } ftype_e;
endpackage

// File: rtl/gop_edge_det.sv
`timescale 1ns/1ps
module gop_edge_det (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl_i,
    output logic rise_o
);
    logic prev_d, prev_q;

    always_comb begin
        prev_d = lvl_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= prev_d;
    end

    assign rise_o = lvl_i & ~prev_q;
endmodule

// File: rtl/gop_qp_sat.sv
`timescale 1ns/1ps
module gop_qp_sat #(
    parameter int QP_W   = 6,
    parameter int QP_MAX = 51
) (
    input  logic [QP_W-1:0] qp_i,
    output logic [QP_W-1:0] qp_o
);
    localparam logic [QP_W-1:0] LIMIT = QP_W'(QP_MAX);

    always_comb begin
        qp_o = (qp_i > LIMIT) ? LIMIT : qp_i;
    end
endmodule

// File: rtl/gop_seq.sv
`timescale 1ns/1ps
module gop_seq
    import gop_pkg::*;
#(
    parameter int PCNT_W = 8,
    parameter int QP_W   = 6,
    parameter int QP_MAX = 51
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rise_i,
    input  logic              force_i,
    input  logic [PCNT_W-1:0] run_i,
    input  logic [QP_W-1:0]   qp_sat_i,
    output ftype_e            ftype_o,
    output logic [QP_W-1:0]   qp_o,
    output logic [PCNT_W-1:0] idx_o,
    output logic              go_o
);
    localparam int IDX_W = PCNT_W;

    typedef struct packed {
        ftype_e             ftype;
        logic [QP_W-1:0]    qp;
        logic [IDX_W-1:0]   idx;
        logic [PCNT_W-1:0]  left;
        logic               pend;
        logic               started;
        logic               go;
    } st_t;

    st_t st_d, st_q;
    logic need_i;

    always_comb begin
        st_d   = st_q;
        need_i = !st_q.started || st_q.pend || force_i || (st_q.left == '0);
        st_d.go = 1'b0;
        if (rise_i) begin
            st_d.go      = 1'b1;
            st_d.started = 1'b1;
            st_d.pend    = 1'b0;
            st_d.qp      = qp_sat_i;
            if (need_i) begin
                st_d.ftype = FT_I;
                st_d.idx   = '0;
                st_d.left  = run_i;
            end else begin
                st_d.ftype = FT_P;
                st_d.idx   = st_q.idx + IDX_W'(1);
                st_d.left  = st_q.left - PCNT_W'(1);
            end
        end else begin
            st_d.pend = st_q.pend | force_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.ftype   <= FT_I;
            st_q.qp      <= '0;
            st_q.idx     <= '0;
            st_q.left    <= '0;
            st_q.pend    <= 1'b0;
            st_q.started <= 1'b0;
            st_q.go      <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ftype_o = st_q.ftype;
    assign qp_o    = st_q.qp;
    assign idx_o   = st_q.idx;
    assign go_o    = st_q.go;

    AST_FIRST_INTRA: assert property (@(posedge clk) disable iff (!rst_n)
        (rise_i && !st_q.started) |=> (st_q.ftype == FT_I)); // R2
    AST_ZERO_LEFT: assert property (@(posedge clk) disable iff (!rst_n)
        (rise_i && st_q.left == '0) |=> (st_q.ftype == FT_I)); // R4
    AST_QP_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.qp <= QP_W'(QP_MAX)); // R5
    AST_FORCE_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        (rise_i && (st_q.pend || force_i)) |=> (st_q.ftype == FT_I)); // R6
    AST_IDX_ZERO_ON_I: assert property (@(posedge clk) disable iff (!rst_n)
        rise_i |=> ((st_q.ftype == FT_I) == (st_q.idx == '0))); // R7
    AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !rise_i |=> ($stable(st_q.ftype) && $stable(st_q.qp) && $stable(st_q.idx))); // R8
    AST_GO_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.go |=> !st_q.go); // R9
endmodule

// File: rtl/gop_ctrl.sv
`timescale 1ns/1ps
module gop_ctrl
    import gop_pkg::*;
#(
    parameter int PCNT_W = 8,
    parameter int QP_W   = 6,
    parameter int QP_MAX = 51
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frm_start,
    input  logic              force_intra,
    input  logic [PCNT_W-1:0] p_run,
    input  logic [QP_W-1:0]   qp_in,
    output logic              is_intra,
    output logic [QP_W-1:0]   qp_out,
    output logic [PCNT_W-1:0] frame_idx,
    output logic              frame_go
);
    logic            rise;
    logic [QP_W-1:0] qp_sat;
    ftype_e          ftype;

    gop_edge_det u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .lvl_i  (frm_start),
        .rise_o (rise)
    );

    gop_qp_sat #(.QP_W(QP_W), .QP_MAX(QP_MAX)) u_sat (
        .qp_i (qp_in),
        .qp_o (qp_sat)
    );

    gop_seq #(.PCNT_W(PCNT_W), .QP_W(QP_W), .QP_MAX(QP_MAX)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .rise_i   (rise),
        .force_i  (force_intra),
        .run_i    (p_run),
        .qp_sat_i (qp_sat),
        .ftype_o  (ftype),
        .qp_o     (qp_out),
        .idx_o    (frame_idx),
        .go_o     (frame_go)
    );

    assign is_intra = (ftype == FT_I);

    AST_GO_ON_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_start && $past(frm_start)) |=> !frame_go); // R1
endmodule

// File: tb/gop_ctrl_tb_top.sv
`timescale 1ns/1ps
module gop_ctrl_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       frm_start = 1'b0;
    logic       force_intra = 1'b0;
    logic [7:0] p_run = 8'd0;
    logic [5:0] qp_in = 6'd0;
    logic       is_intra;
    logic [5:0] qp_out;
    logic [7:0] frame_idx;
    logic       frame_go;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    gop_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .frm_start(frm_start), .force_intra(force_intra),
        .p_run(p_run), .qp_in(qp_in), .is_intra(is_intra), .qp_out(qp_out),
        .frame_idx(frame_idx), .frame_go(frame_go)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic chk_out(input int ei, input int eq, input int en, input string req);
        chk(is_intra == ei[0], {req, " type"}, int'(is_intra), ei);
        chk(int'(qp_out) == eq, {req, " qp"}, int'(qp_out), eq);
        chk(int'(frame_idx) == en, {req, " idx"}, int'(frame_idx), en);
    endtask

    // one frame: edge, check the new outputs and the go marker, then idle
    task automatic frame(input int ei, input int eq, input int en, input string req);
        @(negedge clk) frm_start = 1'b1;
        @(negedge clk);
        chk(frame_go == 1'b1, "R9 go high", int'(frame_go), 1);
        chk_out(ei, eq, en, req);
        frm_start = 1'b0;
        @(negedge clk);
        chk(frame_go == 1'b0, "R9 go low", int'(frame_go), 0);
        repeat (2) @(negedge clk);
    endtask

    task automatic t_reset();
        chk_out(1, 0, 0, "R2 reset");
        chk(frame_go == 1'b0, "R2 go", int'(frame_go), 0);
    endtask

    task automatic t_run2();
        p_run = 8'd2; qp_in = 6'd20;
        frame(1, 20, 0, "R2 first");
        frame(0, 20, 1, "R3 p1");
        frame(0, 20, 2, "R7 p2");
        frame(1, 20, 0, "R3 i");
        frame(0, 20, 1, "R7 p1b");
    endtask

    task automatic t_zero();
        p_run = 8'd0;
        frame(0, 20, 2, "R3 tail");
        frame(1, 20, 0, "R4 a");
        frame(1, 20, 0, "R4 b");
        frame(1, 20, 0, "R4 c");
    endtask

    task automatic t_qp();
        qp_in = 6'd60; frame(1, 51, 0, "R5 60");
        qp_in = 6'd51; frame(1, 51, 0, "R5 51");
        qp_in = 6'd52; frame(1, 51, 0, "R5 52");
        qp_in = 6'd63; frame(1, 51, 0, "R5 63");
        qp_in = 6'd0;  frame(1, 0, 0, "R5 0");
    endtask

    task automatic t_midframe();
        p_run = 8'd3; qp_in = 6'd30;
        frame(1, 30, 0, "R8 base");
        @(negedge clk) qp_in = 6'd45; p_run = 8'd0;
        repeat (3) @(negedge clk);
        chk_out(1, 30, 0, "R8 hold");
        frame(0, 45, 1, "R8 next");
        p_run = 8'd3;
        frame(0, 45, 2, "R8 p2");
    endtask

    task automatic t_force_mid();
        @(negedge clk) force_intra = 1'b1;
        @(negedge clk) force_intra = 1'b0;
        repeat (2) @(negedge clk);
        chk_out(0, 45, 2, "R6 no effect now");
        frame(1, 45, 0, "R6 forced");
        frame(0, 45, 1, "R6 restart1");
        frame(0, 45, 2, "R6 restart2");
    endtask

    task automatic t_force_same();
        @(negedge clk) begin frm_start = 1'b1; force_intra = 1'b1; end
        @(negedge clk);
        force_intra = 1'b0;
        chk_out(1, 45, 0, "R6 coincident");
        frm_start = 1'b0;
        repeat (3) @(negedge clk);
        frame(0, 45, 1, "R6 after coincident");
    endtask

    task automatic t_level();
        int gos = 0;
        @(negedge clk) frm_start = 1'b1;
        for (int k = 0; k < 20; k++) begin
            @(negedge clk);
            if (frame_go) gos++;
        end
        chk(gos == 1, "R1 one go per edge", gos, 1);
        chk_out(0, 45, 2, "R1 held level");
        frm_start = 1'b0;
        repeat (2) @(negedge clk);
        frame(0, 45, 3, "R1 next edge");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_reset();
        t_run2();
        t_zero();
        t_qp();
        t_midframe();
        t_force_mid();
        t_force_same();
        t_level();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #4000000;
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule